// File: doc/BRIEF.md
# Debug Transfer Mailbox

This block sits between a host link and a target console that share one SDRAM. It moves bulk data in either direction by starting jobs on an external DMA engine. The host side is a stream of 32-bit words. The target side is a register-style request port that returns a result word and an error flag for each request.

A host word whose upper 24 bits carry the command token is a command. Its low byte is the command code, and two argument words follow it. A data command (code 0x44) marks the host as waiting for the target. The target later names a destination address, and that starts a DMA into SDRAM. In the other direction, the target names an address and a length, which makes a transfer pending. The controller then starts a DMA out of SDRAM as soon as it is idle and the engine is free.

A request that would disturb a transfer already pending or ready is refused with an error. Nothing is queued.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset the controller is idle and no flag is set. hostWaiting, dmaStart, respValid and dbgAck are low, and a status request (opcode 2) returns 0.
- R2: With hostValid high in the idle state, hostPop is high in the same cycle. A word whose bits 31:8 equal 0x434D44 is taken as a command with code bits 7:0, and exactly two further words are then popped as its arguments.
- R3: A word that is popped in the idle state without the command token makes respValid high for one cycle, starting the cycle after it is popped, with respWord = 0x45525221.
- R4: A command whose code is not 0x44 pops its two argument words and then produces the error response 0x455252 followed by the code byte. The captured argument and length that the target reads do not change.
- R5: A 0x44 command sets hostWaiting from the cycle after its second argument is popped. Opcode 3 then returns the first argument and opcode 4 returns the second argument truncated to LEN_W bits. Host words are not popped until that transfer ends.
- R6: A request sampled with dbgReq is answered in the next cycle with a one-cycle dbgAck, plus dbgResult and dbgErr. The opcodes are 0 write-address, 1 write-length-and-start, 2 status, 3 read-argument, 4 read-length and 5 read-address-and-start. Opcodes 6 and 7 return dbgErr=1 and result 0.
- R7: Opcode 0 stores the target-to-host address. Opcode 1 stores the length and sets pending. While a transfer is pending, both are refused with dbgErr=1 and change nothing. Opcode 2 returns pending in bit 0. Write and start opcodes return result 0.
- R8: When the controller is idle, no host word is offered and a transfer is pending, it raises dmaStart for one cycle with dmaDir=1 and the stored address and length. Pending clears when dmaBusy falls.
- R9: If no host-to-target transfer is ready, opcode 5 stores its argument as the destination, marks the transfer ready and clears hostWaiting. If one is already ready, opcode 5 returns dbgErr=1 and changes nothing.
- R10: After a 0x44 command, once the transfer is ready, dmaStart pulses with dmaDir=0, the opcode 5 address and the command's length. When dmaBusy falls, ready clears, respWord 0x434D5044 is emitted with respValid, and the controller returns to idle.
- R11: No DMA is started while dmaBusy is high.
- R12: In the idle state, a host word that is offered is handled before a pending DMA start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostValid | input | 1 | Host word available |
| hostWord | input | 32 | Host word |
| hostPop | output | 1 | Host word consumed at this edge |
| respValid | output | 1 | Response word valid (one cycle) |
| respWord | output | 32 | Completion or error response |
| dbgReq | input | 1 | Target debug request strobe |
| dbgOp | input | 3 | Debug opcode |
| dbgArg | input | 32 | Debug argument |
| dbgAck | output | 1 | Debug answer valid (one cycle) |
| dbgResult | output | 32 | Debug result word |
| dbgErr | output | 1 | Debug request refused |
| hostWaiting | output | 1 | Host data waiting for the target |
| dmaStart | output | 1 | One-cycle DMA launch |
| dmaDir | output | 1 | 1 = out of SDRAM, 0 = into SDRAM |
| dmaAddr | output | ADDR_W | DMA SDRAM address |
| dmaLen | output | LEN_W | DMA length |
| dmaBusy | input | 1 | DMA engine busy |

## Verification
The bench builds the block with ADDR_W=24 and LEN_W=16, which are narrower than the 32-bit words that carry these values. This makes the truncation of addresses at dmaAddr, and of lengths at dmaLen and in read-length results, visible. The bench drives dmaBusy itself. It can therefore hold the engine busy while a transfer is pending, which exposes the refusal paths and the priority of a host word over the DMA start.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;
  localparam logic [23:0] TOK_CMD = 24'h434D44;
  localparam logic [23:0] TOK_CMP = 24'h434D50;
  localparam logic [23:0] TOK_ERR = 24'h455252;
  localparam logic [7:0] CODE_DATA = 8'h44;
  localparam logic [7:0] CODE_BANG = 8'h21;

  typedef enum logic [2:0] {
    OP_WR_ADDR = 3'd0,
    OP_WR_LEN  = 3'd1,
    OP_WR_STAT = 3'd2,
    OP_RD_ARG  = 3'd3,
    OP_RD_LEN  = 3'd4,
    OP_RD_ADDR = 3'd5
  } dbgOp_e;

  typedef enum logic [1:0] {RES_ZERO, RES_STATUS, RES_ARG, RES_LEN} resSel_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ARGS, ST_T2H, ST_H2T} state_e;

  typedef struct packed {
    logic    latchCode;
    logic    holdArg;
    logic    commitData;
    logic    setT2hAddr;
    logic    setT2hLen;
    logic    setH2tAddr;
    logic    respLoad;
    logic    respErr;
    logic    respBang;
    logic    resLoad;
    resSel_e resSel;
    logic    statusBit;
  } strobe_t;
endpackage

// File: rtl/dbg_mbox_dp.sv
module dbg_mbox_dp
  import dbg_mbox_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [31:0]       hostWord,
  input  logic [31:0]       dbgArg,
  output logic [7:0]        curCode,
  output logic [31:0]       dbgResult,
  output logic [31:0]       respWord,
  output logic [ADDR_W-1:0] t2hAddr,
  output logic [LEN_W-1:0]  t2hLen,
  output logic [ADDR_W-1:0] h2tAddr,
  output logic [LEN_W-1:0]  h2tLen
);
  logic [7:0]        codeQ;
  logic [31:0]       argHoldQ, dArgQ, resQ, respQ;
  logic [LEN_W-1:0]  dLenQ, t2hLenQ;
  logic [ADDR_W-1:0] t2hAddrQ, h2tAddrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      codeQ    <= '0;
      argHoldQ <= '0;
      dArgQ    <= '0;
      dLenQ    <= '0;
      t2hAddrQ <= '0;
      t2hLenQ  <= '0;
      h2tAddrQ <= '0;
      resQ     <= '0;
      respQ    <= '0;
    end else begin
      if (stb.latchCode) codeQ <= hostWord[7:0];
      if (stb.holdArg) argHoldQ <= hostWord;
      if (stb.commitData) begin
        dArgQ <= argHoldQ;
        dLenQ <= hostWord[LEN_W-1:0];
      end
      if (stb.setT2hAddr) t2hAddrQ <= dbgArg[ADDR_W-1:0];
      if (stb.setT2hLen) t2hLenQ <= dbgArg[LEN_W-1:0];
      if (stb.setH2tAddr) h2tAddrQ <= dbgArg[ADDR_W-1:0];
      if (stb.resLoad) begin
        case (stb.resSel)
          RES_STATUS: resQ <= {31'd0, stb.statusBit};
          RES_ARG:    resQ <= dArgQ;
          RES_LEN:    resQ <= 32'(dLenQ);
          default:    resQ <= '0;
        endcase
      end
      if (stb.respLoad)
        respQ <= {stb.respErr ? TOK_ERR : TOK_CMP, stb.respBang ? CODE_BANG : codeQ};
    end
  end

  assign curCode   = codeQ;
  assign dbgResult = resQ;
  assign respWord  = respQ;
  assign t2hAddr   = t2hAddrQ;
  assign t2hLen    = t2hLenQ;
  assign h2tAddr   = h2tAddrQ;
  assign h2tLen    = dLenQ;
endmodule

// File: rtl/dbg_mbox_ctrl.sv
module dbg_mbox_ctrl
  import dbg_mbox_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        hostValid,
  input  logic [23:0] hostTok,
  input  logic        dbgReq,
  input  logic [2:0]  dbgOp,
  input  logic        dmaBusy,
  input  logic [7:0]  curCode,
  output logic        hostPop,
  output strobe_t     stb,
  output logic        dbgAck,
  output logic        dbgErr,
  output logic        respValid,
  output logic        hostWaiting,
  output logic        dmaStart,
  output logic        dmaDir
);
  state_e stateQ, stateD;
  logic argCntQ, argCntD, pendQ, pendD, readyQ, readyD, waitQ, waitD;
  logic launchQ, launchD, startQ, startD, dirQ, dirD, ackQ, ackD, errQ, errD;
  logic respQ, respD, busyQ, busyFall;

  assign busyFall = busyQ & ~dmaBusy;

  always_comb begin
    stb = '0;
    stateD = stateQ; argCntD = argCntQ; pendD = pendQ; readyD = readyQ;
    waitD = waitQ; launchD = launchQ; dirD = dirQ;
    startD = 1'b0; ackD = 1'b0; errD = 1'b0; respD = 1'b0; hostPop = 1'b0;

    if (dbgReq) begin
      ackD = 1'b1;
      stb.resLoad = 1'b1;
      stb.resSel = RES_ZERO;
      case (dbgOp_e'(dbgOp))
        OP_WR_ADDR: if (pendQ) errD = 1'b1; else stb.setT2hAddr = 1'b1;
        OP_WR_LEN: begin
          if (pendQ) errD = 1'b1;
          else begin
            stb.setT2hLen = 1'b1;
            pendD = 1'b1;
          end
        end
        OP_WR_STAT: begin
          stb.resSel = RES_STATUS;
          stb.statusBit = pendQ;
        end
        OP_RD_ARG: stb.resSel = RES_ARG;
        OP_RD_LEN: stb.resSel = RES_LEN;
        OP_RD_ADDR: begin
          if (readyQ) errD = 1'b1;
          else begin
            stb.setH2tAddr = 1'b1;
            readyD = 1'b1;
            waitD = 1'b0;
          end
        end
        default: errD = 1'b1;
      endcase
    end

    case (stateQ)
      ST_IDLE: begin
        if (hostValid) begin
          hostPop = 1'b1;
          if (hostTok == TOK_CMD) begin
            stb.latchCode = 1'b1;
            argCntD = 1'b0;
            stateD = ST_ARGS;
          end else begin
            respD = 1'b1;
            stb.respLoad = 1'b1;
            stb.respErr = 1'b1;
            stb.respBang = 1'b1;
          end
        end else if (pendQ && !dmaBusy) begin
          startD = 1'b1;
          dirD = 1'b1;
          stateD = ST_T2H;
        end
      end
      ST_ARGS: begin
        if (hostValid) begin
          hostPop = 1'b1;
          if (!argCntQ) begin
            stb.holdArg = 1'b1;
            argCntD = 1'b1;
          end else if (curCode == CODE_DATA) begin
            stb.commitData = 1'b1;
            waitD = 1'b1;
            stateD = ST_H2T;
          end else begin
            respD = 1'b1;
            stb.respLoad = 1'b1;
            stb.respErr = 1'b1;
            stateD = ST_IDLE;
          end
        end
      end
      ST_T2H: begin
        if (busyFall) begin
          pendD = 1'b0;
          stateD = ST_IDLE;
        end
      end
      default: begin
        if (!launchQ) begin
          if (readyQ && !dmaBusy) begin
            startD = 1'b1;
            dirD = 1'b0;
            launchD = 1'b1;
          end
        end else if (busyFall) begin
          readyD = 1'b0;
          launchD = 1'b0;
          respD = 1'b1;
          stb.respLoad = 1'b1;
          stateD = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE; argCntQ <= 1'b0; pendQ <= 1'b0; readyQ <= 1'b0;
      waitQ <= 1'b0; launchQ <= 1'b0; startQ <= 1'b0; dirQ <= 1'b0;
      ackQ <= 1'b0; errQ <= 1'b0; respQ <= 1'b0; busyQ <= 1'b0;
    end else begin
      stateQ <= stateD; argCntQ <= argCntD; pendQ <= pendD; readyQ <= readyD;
      waitQ <= waitD; launchQ <= launchD; startQ <= startD; dirQ <= dirD;
      ackQ <= ackD; errQ <= errD; respQ <= respD; busyQ <= dmaBusy;
    end
  end

  assign dbgAck      = ackQ;
  assign dbgErr      = errQ;
  assign respValid   = respQ;
  assign hostWaiting = waitQ;
  assign dmaStart    = startQ;
  assign dmaDir      = dirQ;

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (rst)
    dbgReq |=> ackQ); // R6
  AST_LEN_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (dbgReq && pendQ && dbgOp == 3'd1) |=> errQ); // R7
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    startQ |=> !startQ); // R8
  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    startQ |-> $past(!dmaBusy)); // R11
  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(readyQ) |-> $past(stateQ) == ST_H2T); // R10
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(pendQ) |-> $past(stateQ) == ST_T2H); // R8
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbg_mbox_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostValid,
  input  logic [31:0]       hostWord,
  output logic              hostPop,
  output logic              respValid,
  output logic [31:0]       respWord,
  input  logic              dbgReq,
  input  logic [2:0]        dbgOp,
  input  logic [31:0]       dbgArg,
  output logic              dbgAck,
  output logic [31:0]       dbgResult,
  output logic              dbgErr,
  output logic              hostWaiting,
  output logic              dmaStart,
  output logic              dmaDir,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [LEN_W-1:0]  dmaLen,
  input  logic              dmaBusy
);
  strobe_t           stb;
  logic [7:0]        curCode;
  logic [ADDR_W-1:0] t2hAddr, h2tAddr;
  logic [LEN_W-1:0]  t2hLen, h2tLen;

  dbg_mbox_ctrl ctrl (
    .clk(clk), .rst(rst), .hostValid(hostValid), .hostTok(hostWord[31:8]),
    .dbgReq(dbgReq), .dbgOp(dbgOp), .dmaBusy(dmaBusy), .curCode(curCode),
    .hostPop(hostPop), .stb(stb), .dbgAck(dbgAck), .dbgErr(dbgErr),
    .respValid(respValid), .hostWaiting(hostWaiting), .dmaStart(dmaStart),
    .dmaDir(dmaDir)
  );

  dbg_mbox_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dp (
    .clk(clk), .rst(rst), .stb(stb), .hostWord(hostWord), .dbgArg(dbgArg),
    .curCode(curCode), .dbgResult(dbgResult), .respWord(respWord),
    .t2hAddr(t2hAddr), .t2hLen(t2hLen), .h2tAddr(h2tAddr), .h2tLen(h2tLen)
  );

  assign dmaAddr = dmaDir ? t2hAddr : h2tAddr;
  assign dmaLen  = dmaDir ? t2hLen : h2tLen;
endmodule

// File: tb/dbg_mailbox_test.sv
`timescale 1ns/1ps
module dbg_mailbox_test;
  localparam int ADDR_W = 24;
  localparam int LEN_W  = 16;
  localparam logic [31:0] AMASK = (32'd1 << ADDR_W) - 1;
  localparam logic [31:0] LMASK = (32'd1 << LEN_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hostValid = 1'b0;
  logic [31:0] hostWord = '0;
  logic hostPop, respValid, dbgAck, dbgErr, hostWaiting, dmaStart, dmaDir;
  logic [31:0] respWord, dbgResult;
  logic dbgReq = 1'b0;
  logic [2:0] dbgOp = '0;
  logic [31:0] dbgArg = '0;
  logic [ADDR_W-1:0] dmaAddr;
  logic [LEN_W-1:0] dmaLen;
  logic dmaBusy = 1'b0;

  int checks = 0;
  int failures = 0;

  logic mPend = 0, mReady = 0, mWait = 0;
  logic [31:0] mT2hAddr = 0, mT2hLen = 0, mH2tAddr = 0, mDArg = 0, mDLen = 0;

  always #2 clk = ~clk;

  dbg_mailbox #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .hostValid(hostValid), .hostWord(hostWord),
    .hostPop(hostPop), .respValid(respValid), .respWord(respWord),
    .dbgReq(dbgReq), .dbgOp(dbgOp), .dbgArg(dbgArg), .dbgAck(dbgAck),
    .dbgResult(dbgResult), .dbgErr(dbgErr), .hostWaiting(hostWaiting),
    .dmaStart(dmaStart), .dmaDir(dmaDir), .dmaAddr(dmaAddr), .dmaLen(dmaLen),
    .dmaBusy(dmaBusy)
  );

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] respExp(input logic err, input logic [7:0] code);
    return {err ? 24'h455252 : 24'h434D50, code};
  endfunction

  task automatic modelDbg(input int op, input logic [31:0] arg,
                          output logic [31:0] r, output logic e);
    r = 0; e = 0;
    case (op)
      0: if (mPend) e = 1; else mT2hAddr = arg & AMASK;
      1: if (mPend) e = 1; else begin mT2hLen = arg & LMASK; mPend = 1; end
      2: r = {31'd0, mPend};
      3: r = mDArg;
      4: r = mDLen;
      5: if (mReady) e = 1; else begin mReady = 1; mH2tAddr = arg & AMASK; mWait = 0; end
      default: e = 1;
    endcase
  endtask

  task automatic doDbg(input int op, input logic [31:0] arg, input string tag);
    logic [31:0] r;
    logic e;
    modelDbg(op, arg, r, e);
    dbgReq = 1'b1; dbgOp = 3'(op); dbgArg = arg;
    cyc();
    dbgReq = 1'b0;
    check({tag, " ack"}, 32'(dbgAck), 32'd1);
    check({tag, " result"}, dbgResult, r);
    check({tag, " err"}, 32'(dbgErr), 32'(e));
  endtask

  task automatic sendWord(input logic [31:0] w, input string tag);
    hostValid = 1'b1; hostWord = w;
    #1 check({tag, " pop"}, 32'(hostPop), 32'd1);
    cyc();
    hostValid = 1'b0;
  endtask

  task automatic runDma(input string tag);
    dmaBusy = 1'b1; cyc();
    dmaBusy = 1'b0; cyc();
    check({tag, " start dropped"}, 32'(dmaStart), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) cyc();
    rst = 1'b0;
    // R1 reset state
    check("R1 hostWaiting", 32'(hostWaiting), 0);
    check("R1 dmaStart", 32'(dmaStart), 0);
    check("R1 respValid", 32'(respValid), 0);
    check("R1 dbgAck", 32'(dbgAck), 0);
    doDbg(2, 0, "R1 status after reset");

    // R3 non-token word
    sendWord(32'h12345678, "R3 bad word");
    check("R3 respValid", 32'(respValid), 1);
    check("R3 respWord", respWord, respExp(1'b1, 8'h21));
    cyc();
    check("R3 single pulse", 32'(respValid), 0);

    // R2/R4 unknown command code
    sendWord(32'h434D4458, "R2 token");
    check("R2 no response on token", 32'(respValid), 0);
    sendWord(32'h11111111, "R2 arg0");
    check("R2 no response after arg0", 32'(respValid), 0);
    sendWord(32'h22222222, "R2 arg1");
    check("R4 respValid", 32'(respValid), 1);
    check("R4 respWord", respWord, respExp(1'b1, 8'h58));
    doDbg(3, 0, "R4 arg unchanged");
    doDbg(4, 0, "R4 len unchanged");

    // R5 data command
    sendWord(32'h434D4444, "R5 token");
    sendWord(32'hCAFE0001, "R5 arg0");
    sendWord(32'h00012345, "R5 arg1");
    mWait = 1; mDArg = 32'hCAFE0001; mDLen = 32'h00012345 & LMASK;
    check("R5 hostWaiting", 32'(hostWaiting), 1);
    hostValid = 1'b1; hostWord = 32'h434D4400;
    #1 check("R5 no pop during transfer", 32'(hostPop), 0);
    hostValid = 1'b0;
    doDbg(3, 0, "R5 read arg");
    doDbg(4, 0, "R5 read len");
    check("R10 no start before ready", 32'(dmaStart), 0);
    doDbg(6, 32'h1, "R6 opcode 6");
    doDbg(7, 32'h1, "R6 opcode 7");

    // R9/R10 host-to-target
    doDbg(5, 32'h55ABCDEF, "R9 read-address-start");
    check("R9 waiting cleared", 32'(hostWaiting), 0);
    cyc();
    check("R10 dmaStart", 32'(dmaStart), 1);
    check("R10 dmaDir", 32'(dmaDir), 0);
    check("R10 dmaAddr", 32'(dmaAddr), 32'h00ABCDEF);
    check("R10 dmaLen", 32'(dmaLen), 32'h2345);
    doDbg(5, 32'h00000042, "R9 refused while ready");
    dmaBusy = 1'b1; cyc();
    dmaBusy = 1'b0; cyc();
    mReady = 0;
    check("R10 completion valid", 32'(respValid), 1);
    check("R10 completion word", respWord, respExp(1'b0, 8'h44));

    // R7/R11/R12/R8 target-to-host
    dmaBusy = 1'b1;
    doDbg(0, 32'h12AA5500, "R7 write address");
    doDbg(1, 32'h00030100, "R7 write length");
    repeat (3) begin
      cyc();
      check("R11 no start while busy", 32'(dmaStart), 0);
    end
    doDbg(0, 32'h00000BAD, "R7 address refused");
    doDbg(1, 32'h00000BAD, "R7 length refused");
    doDbg(2, 0, "R7 status pending");
    dmaBusy = 1'b0;
    sendWord(32'hDEADBEEF, "R12 host word first");
    check("R12 no start", 32'(dmaStart), 0);
    check("R12 response", respWord, respExp(1'b1, 8'h21));
    cyc();
    check("R8 dmaStart", 32'(dmaStart), 1);
    check("R8 dmaDir", 32'(dmaDir), 1);
    check("R8 dmaAddr", 32'(dmaAddr), 32'h00AA5500);
    check("R8 dmaLen", 32'(dmaLen), 32'h0100);
    dmaBusy = 1'b1; cyc();
    doDbg(2, 0, "R8 pending during DMA");
    dmaBusy = 1'b0; cyc();
    mPend = 0;
    doDbg(2, 0, "R8 pending cleared");

    // random debug traffic, R6 R7 R8 R9
    for (int i = 0; i < 60; i++) begin
      int op;
      logic [31:0] arg;
      op = int'($urandom % 8);
      arg = $urandom;
      doDbg(op, arg, "R6 random request");
      check("R9 random hostWaiting", 32'(hostWaiting), 32'(mWait));
      if (mPend) begin
        cyc();
        check("R8 random start", 32'(dmaStart), 1);
        check("R8 random dir", 32'(dmaDir), 1);
        check("R8 random addr", 32'(dmaAddr), mT2hAddr);
        check("R8 random len", 32'(dmaLen), mT2hLen);
        runDma("R8 random");
        mPend = 0;
      end
    end
    finishRun();
  end
endmodule